// File: doc/BRIEF.md
# DDR3 Command and Address Decoder

This block sits on the memory side of a DDR3 command bus. On every rising clock edge it captures chip select, the three command strobes (RAS#, CAS#, WE#), the bank address, the address bus and the termination request. From those captured values it produces one decoded command per cycle. Each command comes with its qualifiers: target bank, row or column address, the auto-precharge and precharge-all flags, whether the burst is chopped to four beats, and which mode register a LOAD MODE command targets.

The meaning of the address bits depends on the command. A10 is auto-precharge on READ/WRITE and precharge-all on PRECHARGE. A12 selects a chopped burst, but only when the mode register allows on-the-fly selection. The bank bits pick the mode register during LOAD MODE. The block keeps a small shadow of the two mode-register settings that change its own behaviour: the burst-length mode and whether termination is enabled. It uses that shadow to qualify the termination request it passes on.

The command port is a plain strobe and not a stream. There is no ready signal and no back-pressure. A downstream consumer must accept every decoded command in the cycle it is presented.

Top module: `ddr3_cmd_decoder`

## Requirements
- R1: When cs_n is sampled HIGH, the next cycle shows cmd = 7 (NOP), cmd_vld LOW, and cmd_bank, cmd_addr, auto_pre, pre_all, burst_chop and mr_sel all zero, whatever the other inputs are.
- R2: With cs_n LOW, {ras_n,cas_n,we_n} is decoded as 0 = LOAD MODE, 1 = REFRESH, 2 = PRECHARGE, 3 = ACTIVATE, 4 = WRITE, 5 = READ, 6 = ZQ calibration, 7 = NOP. This code appears on cmd one cycle after sampling. cmd_vld pulses HIGH for exactly that cycle for codes 0 to 6 and stays LOW for code 7. REFRESH, ZQ and NOP leave every qualifier at zero.
- R3: ACTIVATE outputs the full 14-bit address as the row on cmd_addr and BA on cmd_bank.
- R4: READ and WRITE output BA on cmd_bank and A10 on auto_pre. cmd_addr carries the column address: the address bus with bits 10 and 12 forced to zero.
- R5: PRECHARGE with A10 LOW gives pre_all = 0 and cmd_bank = BA. With A10 HIGH it gives pre_all = 1 and cmd_bank = 0, whatever BA is. cmd_addr stays zero.
- R6: LOAD MODE outputs BA[1:0] on mr_sel and the whole address bus, as op-code, on cmd_addr. cmd_bank stays zero.
- R7: The burst mode is taken from op-code bits [1:0] of a LOAD MODE to register 0, and burst_chop applies only to READ/WRITE:
  - 01 selects on-the-fly mode, in which A12 LOW gives burst_chop = 1 (BC4) and A12 HIGH gives 0 (BL8).
  - 10 gives a fixed chop (burst_chop = 1).
  - 00 and 11 give a fixed BL8, and A12 is ignored.
- R8: odt_en equals the odt input delayed by one cycle, ANDed with the termination-allowed setting. The setting is taken from a LOAD MODE to register 1: allowed when any of op-code bits 2, 6 or 9 is set, and disallowed when all three are zero. odt does not depend on cs_n.
- R9: Under active-low reset rst_n, all outputs are zero except cmd = 7. The shadow resets to fixed BL8 with termination disallowed.
- R10: A LOAD MODE sampled on edge k changes the shadow so that it applies to commands sampled from edge k+1 on, and to odt_en from edge k+1 on. LOAD MODE to registers 2 and 3, and any LOAD MODE sent while deselected, leaves both settings unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, part of the command code |
| cas_n | input | 1 | Column strobe, part of the command code |
| we_n | input | 1 | Write strobe, part of the command code |
| ba | input | 3 | Bank address / mode-register select |
| addr | input | 14 | Address bus / op-code |
| odt | input | 1 | Termination request |
| cmd_vld | output | 1 | One-cycle strobe for a decoded command |
| cmd | output | 3 | Decoded command code |
| cmd_bank | output | 3 | Target bank |
| cmd_addr | output | 14 | Row, column or op-code |
| auto_pre | output | 1 | Auto-precharge on READ/WRITE |
| pre_all | output | 1 | PRECHARGE applies to all banks |
| burst_chop | output | 1 | 1 = BC4, 0 = BL8 |
| mr_sel | output | 2 | Mode register targeted by LOAD MODE |
| odt_en | output | 1 | Qualified termination enable |

## Verification
Every decoded field and odt_en is due in the cycle after the edge that sampled the inputs. The bench drives inputs on the falling edge and compares on the following falling edge, so each command is checked exactly one register stage later. A mode-register change is due one cycle after the LOAD MODE itself appears on the outputs. For that reason the bench's reference shadow is updated only after the LOAD MODE's own outputs have been checked, and it then applies to the next command and to the next odt_en sample. Directed sequences cover all eight codes with chip select both low and high, both A10 cases, each burst mode with both A12 values, and ignored writes to registers 2 and 3. Seeded random traffic follows.

// File: rtl/ddr3_cmd_pkg.sv
package ddr3_cmd_pkg;
  typedef enum logic [2:0] {
    CMD_LDMODE = 3'd0,
    CMD_REF    = 3'd1,
    CMD_PRE    = 3'd2,
    CMD_ACT    = 3'd3,
    CMD_WR     = 3'd4,
    CMD_RD     = 3'd5,
    CMD_ZQ     = 3'd6,
    CMD_NOP    = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    BL_FIX8 = 2'd0,
    BL_OTF  = 2'd1,
    BL_FIX4 = 2'd2,
    BL_RSVD = 2'd3
  } bl_mode_e;

  localparam int MR_BURST = 0;
  localparam int MR_TERM  = 1;
endpackage

// File: rtl/ddr3_cmd_capture.sv
module ddr3_cmd_capture
  import ddr3_cmd_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BANK_W-1:0] ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              odt,
  output logic              sel_q,
  output cmd_e              code_q,
  output logic [BANK_W-1:0] ba_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              odt_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      code_q <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      odt_q  <= 1'b0;
    end else begin
      sel_q  <= ~cs_n;
      code_q <= cmd_e'({ras_n, cas_n, we_n});
      ba_q   <= ba;
      addr_q <= addr;
      odt_q  <= odt;
    end
  end
endmodule

// File: rtl/ddr3_cmd_decode.sv
module ddr3_cmd_decode
  import ddr3_cmd_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ADDR_W = 14,
  parameter int AP_BIT = 10,
  parameter int BC_BIT = 12,
  parameter int MRS_W  = 2
) (
  input  logic              sel,
  input  cmd_e              code,
  input  logic [BANK_W-1:0] ba,
  input  logic [ADDR_W-1:0] addr,
  input  bl_mode_e          bl_mode,
  output logic              vld,
  output cmd_e              cmd,
  output logic [BANK_W-1:0] bank,
  output logic [ADDR_W-1:0] addr_o,
  output logic              auto_pre,
  output logic              pre_all,
  output logic              chop,
  output logic [MRS_W-1:0]  mr_sel
);
  logic [ADDR_W-1:0] col;

  always_comb begin
    col         = addr;
    col[AP_BIT] = 1'b0;
    col[BC_BIT] = 1'b0;
  end

  always_comb begin
    vld      = 1'b0;
    cmd      = CMD_NOP;
    bank     = '0;
    addr_o   = '0;
    auto_pre = 1'b0;
    pre_all  = 1'b0;
    chop     = 1'b0;
    mr_sel   = '0;
    if (sel) begin
      cmd = code;
      vld = (code != CMD_NOP);
      case (code)
        CMD_LDMODE: begin
          mr_sel = ba[MRS_W-1:0];
          addr_o = addr;
        end
        CMD_ACT: begin
          bank   = ba;
          addr_o = addr;
        end
        CMD_RD, CMD_WR: begin
          bank     = ba;
          addr_o   = col;
          auto_pre = addr[AP_BIT];
          case (bl_mode)
            BL_OTF:  chop = ~addr[BC_BIT];
            BL_FIX4: chop = 1'b1;
            default: chop = 1'b0;
          endcase
        end
        CMD_PRE: begin
          pre_all = addr[AP_BIT];
          bank    = addr[AP_BIT] ? '0 : ba;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ddr3_mode_shadow.sv
module ddr3_mode_shadow
  import ddr3_cmd_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int MRS_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_vld,
  input  logic [MRS_W-1:0]  ld_sel,
  input  logic [ADDR_W-1:0] opcode,
  output bl_mode_e          bl_mode,
  output logic              term_allow
);
  logic term_bits;
  assign term_bits = opcode[2] | opcode[6] | opcode[9];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bl_mode    <= BL_FIX8;
      term_allow <= 1'b0;
    end else if (ld_vld) begin
      if (ld_sel == MRS_W'(MR_BURST)) bl_mode    <= bl_mode_e'(opcode[1:0]);
      if (ld_sel == MRS_W'(MR_TERM))  term_allow <= term_bits;
    end
  end

  // R10
  upper_mr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_vld && ld_sel[1]) |=> ($stable(bl_mode) && $stable(term_allow)));

  // R10
  no_load_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_vld |=> ($stable(bl_mode) && $stable(term_allow)));
endmodule

// File: rtl/ddr3_cmd_decoder.sv
module ddr3_cmd_decoder
  import ddr3_cmd_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ADDR_W = 14,
  parameter int AP_BIT = 10,
  parameter int BC_BIT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BANK_W-1:0] ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              odt,
  output logic              cmd_vld,
  output logic [2:0]        cmd,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              auto_pre,
  output logic              pre_all,
  output logic              burst_chop,
  output logic [1:0]        mr_sel,
  output logic              odt_en
);
  localparam int MRS_W = 2;

  logic              sel_q;
  cmd_e              code_q;
  logic [BANK_W-1:0] ba_q;
  logic [ADDR_W-1:0] addr_q;
  logic              odt_q;
  bl_mode_e          bl_mode;
  logic              term_allow;
  cmd_e              cmd_dec;
  logic              ld_vld;

  ddr3_cmd_capture #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .odt(odt),
    .sel_q(sel_q), .code_q(code_q), .ba_q(ba_q), .addr_q(addr_q), .odt_q(odt_q)
  );

  ddr3_cmd_decode #(.BANK_W(BANK_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT),
                    .BC_BIT(BC_BIT), .MRS_W(MRS_W)) u_dec (
    .sel(sel_q), .code(code_q), .ba(ba_q), .addr(addr_q), .bl_mode(bl_mode),
    .vld(cmd_vld), .cmd(cmd_dec), .bank(cmd_bank), .addr_o(cmd_addr),
    .auto_pre(auto_pre), .pre_all(pre_all), .chop(burst_chop), .mr_sel(mr_sel)
  );

  assign cmd    = cmd_dec;
  assign ld_vld = cmd_vld && (cmd_dec == CMD_LDMODE);

  ddr3_mode_shadow #(.ADDR_W(ADDR_W), .MRS_W(MRS_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .ld_vld(ld_vld), .ld_sel(mr_sel),
    .opcode(cmd_addr), .bl_mode(bl_mode), .term_allow(term_allow)
  );

  assign odt_en = odt_q & term_allow;

  // R1
  deselect_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!cmd_vld && cmd == 3'd7));

  // R5
  pre_all_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_all |-> (cmd_vld && cmd == 3'd2 && cmd_bank == '0));

  // R4
  auto_pre_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_pre |-> (cmd == 3'd4 || cmd == 3'd5));

  // R7
  chop_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_chop |-> (cmd_vld && (cmd == 3'd4 || cmd == 3'd5)));

  // R8
  odt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !odt |=> !odt_en);
endmodule

// File: tb/tb_ddr3_cmd_decoder.sv
module tb_ddr3_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [2:0]  ba = '0;
  logic [13:0] addr = '0;
  logic        odt = 1'b0;
  logic        cmd_vld, auto_pre, pre_all, burst_chop, odt_en;
  logic [2:0]  cmd, cmd_bank;
  logic [13:0] cmd_addr;
  logic [1:0]  mr_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [1:0] m_bl = 2'd0;
  logic       m_term = 1'b0;

  always #2 clk = ~clk;

  ddr3_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .odt(odt),
    .cmd_vld(cmd_vld), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .auto_pre(auto_pre), .pre_all(pre_all), .burst_chop(burst_chop),
    .mr_sel(mr_sel), .odt_en(odt_en)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string req_of(input bit c, input logic [2:0] k);
    if (c) return "R1";
    case (k)
      3'd0: return "R6";
      3'd2: return "R5";
      3'd3: return "R3";
      3'd4, 3'd5: return "R4";
      default: return "R2";
    endcase
  endfunction

  // one command per cycle: drive at negedge, compare at the next negedge
  task automatic step(input bit c, input logic [2:0] k, input logic [2:0] b,
                      input logic [13:0] a, input bit o, input string tag);
    bit          e_vld, e_ap, e_pa, e_bc, e_odt;
    logic [2:0]  e_cmd, e_bank;
    logic [13:0] e_addr;
    logic [1:0]  e_mr;
    string       t;
    cs_n = c; {ras_n, cas_n, we_n} = k; ba = b; addr = a; odt = o;
    e_vld = 0; e_cmd = 3'd7; e_bank = 0; e_addr = 0; e_ap = 0; e_pa = 0;
    e_bc = 0; e_mr = 0;
    if (!c) begin
      e_cmd = k;
      e_vld = (k != 3'd7);
      case (k)
        3'd0: begin e_mr = b[1:0]; e_addr = a; end
        3'd3: begin e_bank = b; e_addr = a; end
        3'd4, 3'd5: begin
          e_bank = b; e_addr = a & ~14'h1400; e_ap = a[10];
          e_bc = (m_bl == 2'd1) ? !a[12] : (m_bl == 2'd2);
        end
        3'd2: begin e_pa = a[10]; e_bank = a[10] ? 3'd0 : b; end
        default: ;
      endcase
    end
    e_odt = o & m_term;
    t = (tag != "") ? tag : req_of(c, k);
    @(negedge clk);
    chk(t, "cmd_vld", int'(cmd_vld), int'(e_vld));
    chk(t, "cmd", int'(cmd), int'(e_cmd));
    chk(t, "cmd_bank", int'(cmd_bank), int'(e_bank));
    chk(t, "cmd_addr", int'(cmd_addr), int'(e_addr));
    chk(t, "auto_pre", int'(auto_pre), int'(e_ap));
    chk(t, "pre_all", int'(pre_all), int'(e_pa));
    chk((tag != "") ? tag : "R7", "burst_chop", int'(burst_chop), int'(e_bc));
    chk(t, "mr_sel", int'(mr_sel), int'(e_mr));
    chk((tag != "") ? tag : "R8", "odt_en", int'(odt_en), int'(e_odt));
    if (!c && k == 3'd0) begin
      if (b[1:0] == 2'd0) m_bl = a[1:0];
      if (b[1:0] == 2'd1) m_term = a[2] | a[6] | a[9];
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    cs_n = 1'b0; {ras_n, cas_n, we_n} = 3'b101; addr = 14'h3fff; ba = 3'd7; odt = 1'b1;
    repeat (3) @(negedge clk);
    // R9: outputs held at reset values while rst_n is low
    chk("R9", "cmd_vld", int'(cmd_vld), 0);
    chk("R9", "cmd", int'(cmd), 7);
    chk("R9", "cmd_addr", int'(cmd_addr), 0);
    chk("R9", "odt_en", int'(odt_en), 0);
    rst_n = 1'b1;
    // R9: shadow reset state -> BL8 fixed, termination off
    step(0, 3'd5, 3'd2, 14'h0000, 1, "R9");
    // R1/R2: every code with chip select low and high
    for (int k = 0; k < 8; k++) begin
      if (k != 0) step(0, 3'(k), 3'(k), 14'h2a55, 0, "");
      step(1, 3'(k), 3'(k), 14'h15aa, 0, "");
    end
    // R5: precharge single and all
    step(0, 3'd2, 3'd6, 14'h0000, 0, "R5");
    step(0, 3'd2, 3'd6, 14'h0400, 0, "R5");
    // R7: on-the-fly mode, A12 low then high
    step(0, 3'd0, 3'd0, 14'h0001, 0, "R6");
    step(0, 3'd5, 3'd1, 14'h0000, 0, "R7");
    step(0, 3'd4, 3'd1, 14'h1000, 0, "R7");
    // R10: register 2/3 writes and deselected load mode ignored
    step(0, 3'd0, 3'd2, 14'h0002, 1, "R10");
    step(0, 3'd0, 3'd3, 14'h3fff, 1, "R10");
    step(1, 3'd0, 3'd1, 14'h0204, 1, "R10");
    step(0, 3'd5, 3'd3, 14'h0000, 1, "R10");
    // R7: fixed chop, then fixed BL8 ignores A12
    step(0, 3'd0, 3'd0, 14'h0002, 0, "R7");
    step(0, 3'd4, 3'd0, 14'h1000, 0, "R7");
    step(0, 3'd0, 3'd0, 14'h0000, 0, "R7");
    step(0, 3'd4, 3'd0, 14'h0000, 0, "R7");
    // R8/R10: termination enabled via bit 6, next cycle odt passes
    step(0, 3'd0, 3'd1, 14'h0040, 1, "R8");
    step(1, 3'd7, 3'd0, 14'h0000, 1, "R10");
    step(0, 3'd0, 3'd1, 14'h0000, 1, "R8");
    step(1, 3'd7, 3'd0, 14'h0000, 1, "R8");
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      bit c = ($urandom % 8) == 0;
      logic [2:0]  k = 3'($urandom);
      logic [13:0] a = 14'($urandom);
      step(c, k, 3'($urandom), a, 1'($urandom), "");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule